// File: doc/BRIEF.md
# SDRAM Mode-Programmed Burst Latency Unit

This unit is the device-side timing core of a synchronous DRAM. A load-mode command captures a ten-bit mode word from the address pins. That word sets four things: the read latency, the burst length, whether writes burst or touch a single location, and a required operating-mode field. READ and WRITE commands are then timed against the captured word. A read burst leaves on the data output after the programmed latency. The output enable rises one cycle before the first valid word, so there is one driven cycle with no defined data, which this model shows as zero.

Storage is a small behavioural array of 64 words, indexed by the low six address bits. It exists so that burst order and write behaviour can be seen at the ports. A mode word with any reserved field sets an error flag. While that flag is set, reads and writes are ignored until a legal mode word is loaded. Commands arriving while a burst runs are also ignored.

Top module: `sdram_burst_timer`

## Requirements
- R1: After reset, `dq_oe` is 0, `dq_out` is 0 and `mode_err` is 0. The active mode is latency 2, burst length 1, with writes following the burst length.
- R2: Commands are taken at the rising clock edge from {sel_n, row_strobe_n, col_strobe_n, wr_n}. The encodings are 0000 load-mode, 0101 READ and 0100 WRITE. Any value with sel_n=1, and every other encoding, is a no-op.
- R3: The mode word is laid out as follows. Bits [2:0] give the burst length: 000=1, 001=2, 010=4, 011=8. Bit 3 must be 0. Bits [6:4] give the latency: 010=2, 011=3. Bits [8:7] must be 00. Bit 9=1 selects single-location writes. Any other value of these fields is reserved and makes `mode_err` 1 after the load edge. A legal word makes it 0.
- R4: Let a READ be registered at edge n with latency m. Then `dq_oe` is 1 after edge n+m-1, where `dq_out` is 0. The first word is on `dq_out` after edge n+m, and `dq_oe` is 0 after edge n+m-2. Edges between the command and the data carry no-ops, and timing keeps advancing through them.
- R5: Word i of a read burst (i = 0..BL-1) appears after edge n+m+i. It is read from column (a & ~(BL-1)) | ((a+i) & (BL-1)), where a is the command's column. The order is sequential and wraps inside the aligned block.
- R6: `dq_oe` is 0 after edge n+m+BL, the edge following the last word. `dq_out` is 0 whenever `dq_oe` is 0.
- R7: A WRITE at edge n with bit 9 = 0 stores `wdata` at edges n..n+BL-1. The columns follow the same wrap order as R5.
- R8: With bit 9 = 1, a WRITE stores only at edge n, into the command's column. `wdata` at the following edges is not stored, while reads still use the full burst length.
- R9: READ, WRITE and load-mode commands are ignored while a burst is in progress. For a read, that means edges n+1..n+m+BL-1. For a burst write, it means edges n+1..n+BL-1.
- R10: While `mode_err` is 1, READ and WRITE are ignored, and a load-mode command is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| row_strobe_n | input | 1 | Row strobe command pin, active low |
| col_strobe_n | input | 1 | Column strobe command pin, active low |
| wr_n | input | 1 | Write command pin, active low |
| addr | input | 10 | Mode word on load-mode, column in bits [5:0] on READ/WRITE |
| wdata | input | DATA_W | Write data, taken at each write edge |
| dq_out | output | DATA_W | Read data, zero when not valid |
| dq_oe | output | 1 | Data output enable |
| mode_err | output | 1 | The last loaded mode word was reserved |

## Verification
Reads are issued at latency 2 and at latency 3, with burst lengths 1, 2, 4 and 8. Start columns sit mid-block so that wrap order is separated from plain increment. Two reads are issued back to back at the first edge the unit accepts, which catches an enable that stays high one cycle too long or a new read that is dropped. One write burst is followed by a single-location write over the same block and a readback of the untouched neighbours. Each of the reserved fields is loaded in turn, and commands are issued during an active burst and during the error state. This shows that an ignored command changes neither the stored data nor the timing of later reads.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

    localparam int MODE_W = 10;
    localparam int MAX_BL = 8;
    localparam int LEN_W  = $clog2(MAX_BL) + 1;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_LOAD,
        CMD_READ,
        CMD_WRITE
    } cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_READ,
        PH_WRITE
    } phase_e;

    typedef struct packed {
        logic [LEN_W-1:0] blen;
        logic [1:0]       lat;
        logic             wr_single;
    } mode_t;

    localparam mode_t MODE_RESET = '{blen: LEN_W'(1), lat: 2'd2, wr_single: 1'b0};

endpackage

// File: rtl/sbl_cmd_decode.sv
module sbl_cmd_decode
    import sbl_pkg::*;
(
    input  logic sel_n,
    input  logic row_n,
    input  logic col_n,
    input  logic wr_n,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_IDLE;
        if (!sel_n) begin
            unique case ({row_n, col_n, wr_n})
                3'b000:  cmd = CMD_LOAD;
                3'b101:  cmd = CMD_READ;
                3'b100:  cmd = CMD_WRITE;
                default: cmd = CMD_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sbl_mode_check.sv
module sbl_mode_check
    import sbl_pkg::*;
(
    input  logic [MODE_W-1:0] word,
    output mode_t             mode,
    output logic              bad
);

    logic [2:0] len_code;
    logic [2:0] lat_code;
    logic [1:0] op_code;

    assign len_code = word[2:0];
    assign lat_code = word[6:4];
    assign op_code  = word[8:7];

    always_comb begin
        mode.wr_single = word[9];
        mode.lat       = lat_code[1:0];
        mode.blen      = LEN_W'(1) << len_code[1:0];
        // reserved: long length codes, the wrap-type bit, unknown latencies, non-normal op
        bad = len_code[2]
            | word[3]
            | ((lat_code != 3'd2) && (lat_code != 3'd3))
            | (op_code != 2'b00);
    end

endmodule

// File: rtl/sbl_burst_addr.sv
module sbl_burst_addr
    import sbl_pkg::*;
#(
    parameter int COL_W = 6
) (
    input  logic [COL_W-1:0] start,
    input  logic [LEN_W-1:0] idx,
    input  logic [LEN_W-1:0] blen,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] sum;

    always_comb begin
        mask = COL_W'(blen - LEN_W'(1));
        sum  = start + COL_W'(idx);
        col  = (start & ~mask) | (sum & mask);
    end

endmodule

// File: rtl/sbl_store.sv
module sbl_store #(
    parameter int DATA_W = 32,
    parameter int COL_W  = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [COL_W-1:0]  wcol,
    input  logic [DATA_W-1:0] wdata,
    input  logic [COL_W-1:0]  rcol,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << COL_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[wcol] <= wdata;
    end

    assign rdata = cells[rcol];

endmodule

// File: rtl/sdram_burst_timer.sv
module sdram_burst_timer
    import sbl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int COL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              row_strobe_n,
    input  logic              col_strobe_n,
    input  logic              wr_n,
    input  logic [MODE_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              mode_err
);

    localparam int AGE_W = $clog2(MAX_BL + 4);

    typedef struct packed {
        phase_e            ph;
        logic [AGE_W-1:0]  age;
        logic [COL_W-1:0]  start;
        mode_t             mode;
        logic              err;
        logic              oe;
        logic [DATA_W-1:0] dout;
    } st_t;

    st_t st_d, st_q;

    cmd_e              cmd;
    mode_t             new_mode;
    logic              new_bad;
    logic [COL_W-1:0]  cmd_col;
    logic [AGE_W-1:0]  age_nx;
    logic [AGE_W-1:0]  lat_a;
    logic [AGE_W-1:0]  len_a;
    logic [LEN_W-1:0]  wr_len;
    logic [LEN_W-1:0]  gen_idx;
    logic [COL_W-1:0]  gen_col;
    logic              mem_we;
    logic [COL_W-1:0]  mem_wcol;
    logic [DATA_W-1:0] mem_rdata;
    logic              busy_w;
    mode_t             mode_w;

    assign cmd_col = addr[COL_W-1:0];

    sbl_cmd_decode u_dec (
        .sel_n (sel_n),
        .row_n (row_strobe_n),
        .col_n (col_strobe_n),
        .wr_n  (wr_n),
        .cmd   (cmd)
    );

    sbl_mode_check u_mchk (
        .word (addr),
        .mode (new_mode),
        .bad  (new_bad)
    );

    sbl_burst_addr #(.COL_W(COL_W)) u_bag (
        .start (st_q.start),
        .idx   (gen_idx),
        .blen  (st_q.mode.blen),
        .col   (gen_col)
    );

    sbl_store #(.DATA_W(DATA_W), .COL_W(COL_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .wcol  (mem_wcol),
        .wdata (wdata),
        .rcol  (gen_col),
        .rdata (mem_rdata)
    );

    // derived timing quantities of the running burst
    always_comb begin
        age_nx  = st_q.age + AGE_W'(1);
        lat_a   = AGE_W'(st_q.mode.lat);
        len_a   = AGE_W'(st_q.mode.blen);
        wr_len  = st_q.mode.wr_single ? LEN_W'(1) : st_q.mode.blen;
        gen_idx = (st_q.ph == PH_READ) ? LEN_W'(age_nx - lat_a) : LEN_W'(age_nx);
    end

    // next-state logic
    always_comb begin
        st_d     = st_q;
        st_d.oe  = 1'b0;
        st_d.dout = '0;
        mem_we   = 1'b0;
        mem_wcol = cmd_col;

        unique case (st_q.ph)
            PH_IDLE: begin
                if (cmd == CMD_LOAD) begin
                    st_d.mode = new_mode;
                    st_d.err  = new_bad;
                end else if (!st_q.err && cmd == CMD_READ) begin
                    st_d.ph    = PH_READ;
                    st_d.age   = '0;
                    st_d.start = cmd_col;
                end else if (!st_q.err && cmd == CMD_WRITE) begin
                    mem_we     = 1'b1;
                    st_d.age   = '0;
                    st_d.start = cmd_col;
                    if (wr_len != LEN_W'(1)) st_d.ph = PH_WRITE;
                end
            end
            PH_READ: begin
                st_d.age = age_nx;
                st_d.oe  = (age_nx >= lat_a - AGE_W'(1));
                if (age_nx >= lat_a) st_d.dout = mem_rdata;
                if (age_nx == lat_a + len_a - AGE_W'(1)) st_d.ph = PH_IDLE;
            end
            PH_WRITE: begin
                st_d.age = age_nx;
                mem_we   = 1'b1;
                mem_wcol = gen_col;
                if (age_nx == AGE_W'(wr_len) - AGE_W'(1)) st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= st_t'{ph: PH_IDLE, age: '0, start: '0, mode: MODE_RESET,
                          err: 1'b0, oe: 1'b0, dout: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_out   = st_q.dout;
    assign dq_oe    = st_q.oe;
    assign mode_err = st_q.err;
    assign busy_w   = (st_q.ph != PH_IDLE);
    assign mode_w   = st_q.mode;

endmodule

// File: rtl/sdram_burst_timer_chk.sv
module sdram_burst_timer_chk
    import sbl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dq_oe,
    input logic [DATA_W-1:0] dq_out,
    input logic              mode_err,
    input logic              busy,
    input mode_t             mode
);

    logic [4:0] oe_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              oe_run <= '0;
        else if (!dq_oe)         oe_run <= '0;
        else if (oe_run != 5'h1f) oe_run <= oe_run + 5'd1;
    end

    a_r6_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_out == '0));

    a_r6_oe_window: assert property (@(posedge clk) disable iff (!rst_n)
        oe_run <= 5'(MAX_BL + 1));

    a_r4_lead_cycle_blank: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (busy && dq_out == '0));

    a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(mode) && $stable(mode_err)));

    a_r10_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_err && !busy) |=> !busy);

    a_r3_lat_legal: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_err |-> (mode.lat == 2'd2 || mode.lat == 2'd3));

endmodule

bind sdram_burst_timer sdram_burst_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dq_oe    (dq_oe),
    .dq_out   (dq_out),
    .mode_err (mode_err),
    .busy     (busy_w),
    .mode     (mode_w)
);

// File: tb/sim_sdram_burst_timer.sv
`timescale 1ns/1ps
module sim_sdram_burst_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1, row_n = 1'b1, col_n = 1'b1, wr_n = 1'b1;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] dq_out;
    logic        dq_oe;
    logic        mode_err;

    always #2.5 clk = ~clk;

    sdram_burst_timer u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_n        (sel_n),
        .row_strobe_n (row_n),
        .col_strobe_n (col_n),
        .wr_n         (wr_n),
        .addr         (addr),
        .wdata        (wdata),
        .dq_out       (dq_out),
        .dq_oe        (dq_oe),
        .mode_err     (mode_err)
    );

    localparam logic [3:0] C_LOAD = 4'b0000, C_READ = 4'b0101,
                           C_WRITE = 4'b0100, C_NOP = 4'b0111;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0;

    typedef struct {
        int          edge_no;
        logic        oe;
        logic [31:0] data;
        string       req;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] mdl [64];
    int          cur_lat = 2, cur_bl = 1, cur_ws = 0;
    bit          exp_err = 1'b0;

    function automatic void check(bit ok, string req, string what,
                                  logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h (edge %0d)", req, what, act, exp, cyc);
        end
    endfunction

    function automatic int wrap(int col, int i, int bl);
        return ((col & ~(bl - 1)) | ((col + i) & (bl - 1))) & 63;
    endfunction

    // scoreboard monitor: compares each expected item at its edge
    exp_t e;
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].edge_no <= cyc) begin
            e = sb.pop_front();
            if (e.edge_no < cyc) begin
                check(1'b0, e.req, "missed item", 32'(e.edge_no), 32'(cyc));
            end else begin
                check(dq_oe === e.oe, e.req, "dq_oe", {31'b0, dq_oe}, {31'b0, e.oe});
                check(dq_out === e.data, e.req, "dq_out", dq_out, e.data);
            end
        end
    end

    // all tasks start just after a falling edge
    task automatic drive(input logic [3:0] c, input logic [9:0] a, input logic [31:0] d);
        {sel_n, row_n, col_n, wr_n} = c;
        addr  = a;
        wdata = d;
        @(negedge clk);
        {sel_n, row_n, col_n, wr_n} = C_NOP;
    endtask

    task automatic load_mode(input int blc, input int latc, input int ws,
                             input int opb, input int b3);
        logic [9:0] w;
        bit         legal;
        w = {ws[0], opb[1:0], latc[2:0], b3[0], blc[2:0]};
        legal = (blc < 4) && (latc == 2 || latc == 3) && (opb == 0) && (b3 == 0);
        drive(C_LOAD, w, '0);
        exp_err = !legal;
        if (legal) begin
            cur_bl  = 1 << blc;
            cur_lat = latc;
            cur_ws  = ws;
        end
        check(mode_err === exp_err, "R3", "mode_err after load",
              {31'b0, mode_err}, {31'b0, exp_err});
    endtask

    task automatic rd(input int col);
        int n = cyc + 1;
        sb.push_back('{n + cur_lat - 2, 1'b0, 32'h0, "R4"});
        sb.push_back('{n + cur_lat - 1, 1'b1, 32'h0, "R4"});
        for (int i = 0; i < cur_bl; i++)
            sb.push_back('{n + cur_lat + i, 1'b1, mdl[wrap(col, i, cur_bl)], "R5"});
        sb.push_back('{n + cur_lat + cur_bl, 1'b0, 32'h0, "R6"});
        drive(C_READ, 10'(col), '0);
    endtask

    task automatic rd_blocked(input int col);
        int n = cyc + 1;
        for (int k = 0; k < 7; k++) sb.push_back('{n + k, 1'b0, 32'h0, "R10"});
        drive(C_READ, 10'(col), '0);
    endtask

    task automatic wr(input int col, input logic [31:0] base);
        int wl = cur_ws ? 1 : cur_bl;
        {sel_n, row_n, col_n, wr_n} = C_WRITE;
        addr  = 10'(col);
        wdata = base;
        for (int i = 1; i < cur_bl; i++) begin
            @(negedge clk);
            {sel_n, row_n, col_n, wr_n} = C_NOP;
            wdata = base + 32'(i);
        end
        @(negedge clk);
        {sel_n, row_n, col_n, wr_n} = C_NOP;
        if (!exp_err)
            for (int i = 0; i < wl; i++) mdl[wrap(col, i, cur_bl)] = base + 32'(i);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(dq_oe === 1'b0, "R1", "dq_oe in reset", {31'b0, dq_oe}, 32'h0);
        check(dq_out === 32'h0, "R1", "dq_out in reset", dq_out, 32'h0);
        check(mode_err === 1'b0, "R1", "mode_err in reset", {31'b0, mode_err}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 default mode: latency 2, single word
        wr(5, 32'hA5A5_0000);
        rd(5);
        drain();

        // R5/R7: length 4, latency 2, start mid-block
        load_mode(2, 2, 0, 0, 0);
        wr(10, 32'h0000_1000);
        rd(9);
        drain();

        // R4/R5: length 8, latency 3
        load_mode(3, 3, 0, 0, 0);
        wr(19, 32'h0000_2000);
        rd(22);
        drain();

        // length 2, latency 3
        load_mode(1, 3, 0, 0, 0);
        rd(23);
        drain();

        // R8: single-location writes, reads still burst
        load_mode(2, 3, 0, 0, 0);
        wr(32, 32'h0000_3000);
        load_mode(2, 3, 1, 0, 0);
        wr(33, 32'h0000_4000);
        rd(32);
        drain();

        // R9: commands during an active read burst are ignored
        rd(34);
        drive(C_WRITE, 10'd8, 32'hDEAD_BEEF);
        drive(C_LOAD, 10'h180, '0);
        drain();
        check(mode_err === 1'b0, "R9", "mode_err after busy load", {31'b0, mode_err}, 32'h0);
        rd(8);
        drain();

        // R4/R6: back-to-back reads at the first accepted edge
        load_mode(2, 2, 0, 0, 0);
        rd(9);
        repeat (cur_lat + cur_bl - 1) @(negedge clk);
        rd(12);
        drain();

        // R2: deselected load and unlisted encoding are no-ops
        drive(4'b1000, 10'h180, '0);
        check(mode_err === 1'b0, "R2", "mode_err after deselected load", {31'b0, mode_err}, 32'h0);
        drive(4'b0110, 10'd9, 32'hFFFF_FFFF);
        rd(9);
        drain();

        // R3/R10: reserved fields, commands blocked while flagged
        load_mode(0, 2, 0, 1, 0);
        rd_blocked(5);
        drain();
        wr(5, 32'h0BAD_0000);
        check(mode_err === 1'b1, "R10", "mode_err held", {31'b0, mode_err}, 32'h1);
        load_mode(0, 1, 0, 0, 0);
        load_mode(4, 2, 0, 0, 0);
        load_mode(0, 2, 0, 0, 1);
        load_mode(0, 2, 0, 0, 0);
        rd(5);
        drain();

        finish_up();
    end

endmodule